// File: doc/BRIEF.md
# Register Window Access Validator

This block screens each access that a bus master makes into a window of memory-mapped registers. The address decoder supplies a register-present flag and a per-register sizing rule for every request. The block then rules the access legal or illegal. Its verdict is registered and appears one cycle after the request, together with a two-bit reason code, a write-commit strobe for the register file and a read-data path that is forced to zero when the access is refused.

An illegal access made by the CPU raises an error pulse. The pulse goes to the core side when the address lies in the core register region, which starts at a parameterised base address and runs upward. It goes to the system side when the address lies below that base. Both kinds of error also load the offending address and its direction into a held fault record. Requests from other initiators, such as a DMA engine or a debug port, are refused in the same way but raise no error and leave the fault record unchanged.

Top module: `rwv_access_validator`

## Requirements
- R1: An access whose address bits [1:0] are not both zero is refused, whatever its byte count.
- R2: When `reg_mode` is 0 (fixed size), an access is accepted only if `req_nbytes` equals `reg_size`; any other count gives reason 3.
- R3: When `reg_mode` is 1 (half or word), an aligned access with `req_nbytes` of 2 or 4 is accepted; any other count gives reason 3.
- R4: An access with `reg_present` low is refused with reason 1 (missing).
- R5: When several faults apply, the reason is chosen in this order: missing (1), then misaligned (2), then bad length (3).
- R6: A refused CPU access at or above `CORE_BASE` pulses `core_fault`, and `fault_addr` and `fault_write` take the request's address and write flag.
- R7: A refused CPU access below `CORE_BASE` pulses `sys_hwerr` and does not pulse `core_fault`.
- R8: A refused access with `req_from_cpu` low pulses neither error output and leaves `fault_addr` unchanged.
- R9: The region compare is unsigned and includes the base: address `CORE_BASE` routes to the core side, and address `CORE_BASE-4` routes to the system side.
- R10: `resp_valid`, `resp_accept` and `resp_reason` (0 OK, 1 missing, 2 misaligned, 3 bad length) appear on the first clock edge after the request is sampled. Accept and reason hold their values until the next request.
- R11: Each error output is high for one cycle per refused request. `fault_addr` holds its value until the next error.
- R12: `wr_commit` pulses only for an accepted write. `rd_data` carries the sampled `reg_rdata` only for an accepted read and is zero in every other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | AW | Byte address of the access |
| req_nbytes | input | NBW | Byte count of the access |
| req_write | input | 1 | 1 for write, 0 for read |
| req_from_cpu | input | 1 | Initiator is the CPU |
| reg_present | input | 1 | Decoder found a register at the address |
| reg_mode | input | 1 | 0 fixed size, 1 half or word allowed |
| reg_size | input | NBW | Declared size of the register in bytes |
| reg_rdata | input | DW | Read data offered by the register file |
| resp_valid | output | 1 | Verdict strobe, one cycle after the request |
| resp_accept | output | 1 | Last request was legal |
| resp_reason | output | 2 | Reason code of the last request |
| wr_commit | output | 1 | Accepted write may update the register |
| rd_data | output | DW | Read data returned, zero when refused |
| core_fault | output | 1 | Core-side fault pulse |
| sys_hwerr | output | 1 | System-side hardware-error pulse |
| fault_addr | output | AW | Address of the latest signalled fault |
| fault_write | output | 1 | Direction of the latest signalled fault |

## Verification
Two things can land in the same cycle. One is the error pulse of a refused request. The other is the verdict of the next request, which arrives back to back: that verdict may itself be refused and routed to the other region. The bench sends a misaligned core-region access and then, in the very next cycle, a missing system-region register. It checks that `core_fault` and `sys_hwerr` each pulse in their own cycle and never together, and that `fault_addr` moves from the first address to the second. A separate request that is both missing and misaligned exercises the reason priority while routing takes place in the same cycle.

// File: rtl/rwv_pkg.sv
package rwv_pkg;

  typedef enum logic [1:0] {
    RSN_OK        = 2'd0,
    RSN_MISSING   = 2'd1,
    RSN_UNALIGNED = 2'd2,
    RSN_BADLEN    = 2'd3
  } rsn_e;

  typedef enum logic {
    MODE_FIXED     = 1'b0,
    MODE_HALF_WORD = 1'b1
  } size_mode_e;

  // Word alignment looks only at the two least significant address bits.
  function automatic logic word_aligned(input logic [1:0] lsb);
    return (lsb == 2'b00);
  endfunction

  // Length rule per register mode; counts are passed zero-extended to 8 bits.
  function automatic logic length_fits(input size_mode_e mode,
                                       input logic [7:0] nbytes,
                                       input logic [7:0] size);
    logic ok;
    if (mode == MODE_HALF_WORD) ok = (nbytes == 8'd2) || (nbytes == 8'd4);
    else                        ok = (nbytes == size);
    return ok;
  endfunction

  // Fixed priority: missing, then misaligned, then length.
  function automatic rsn_e rank_reason(input logic present,
                                       input logic aligned,
                                       input logic len_ok);
    rsn_e r;
    if (!present)     r = RSN_MISSING;
    else if (!aligned) r = RSN_UNALIGNED;
    else if (!len_ok)  r = RSN_BADLEN;
    else               r = RSN_OK;
    return r;
  endfunction

endpackage

// File: rtl/rwv_rule_check.sv
module rwv_rule_check
  import rwv_pkg::*;
#(
  parameter int AW  = 32,
  parameter int NBW = 3
) (
  input  logic [AW-1:0]  addr,
  input  logic [NBW-1:0] nbytes,
  input  logic           present,
  input  logic           mode,
  input  logic [NBW-1:0] size,
  output logic           aligned,
  output logic           len_ok,
  output rsn_e           reason
);
  localparam int PADW = 8 - NBW;

  logic [7:0] nb_ext;
  logic [7:0] sz_ext;

  generate
    if (PADW > 0) begin : g_pad
      assign nb_ext = {{PADW{1'b0}}, nbytes};
      assign sz_ext = {{PADW{1'b0}}, size};
    end else begin : g_nopad
      assign nb_ext = nbytes[7:0];
      assign sz_ext = size[7:0];
    end
  endgenerate

  always_comb begin
    aligned = word_aligned(addr[1:0]);
    len_ok  = length_fits(size_mode_e'(mode), nb_ext, sz_ext);
    reason  = rank_reason(present, aligned, len_ok);
  end
endmodule

// File: rtl/rwv_route.sv
module rwv_route #(
  parameter int            AW        = 32,
  parameter logic [AW-1:0] CORE_BASE = 32'hFFE0_0000
) (
  input  logic [AW-1:0] addr,
  input  logic          reject,
  input  logic          from_cpu,
  output logic          in_core,
  output logic          hit_core,
  output logic          hit_sys
);
  localparam bool_zero_base = (CORE_BASE == '0);

  generate
    if (bool_zero_base) begin : g_all_core
      assign in_core = 1'b1;
    end else begin : g_split
      assign in_core = (addr >= CORE_BASE);
    end
  endgenerate

  logic signal_err;
  assign signal_err = reject && from_cpu;
  assign hit_core   = signal_err && in_core;
  assign hit_sys    = signal_err && !in_core;
endmodule

// File: rtl/rwv_resp_reg.sv
module rwv_resp_reg
  import rwv_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  rsn_e          reason,
  input  logic          write,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] rdata_in,
  input  logic          hit_core,
  input  logic          hit_sys,
  output logic          resp_valid,
  output logic          resp_accept,
  output logic [1:0]    resp_reason,
  output logic          wr_commit,
  output logic [DW-1:0] rd_data,
  output logic          core_fault,
  output logic          sys_hwerr,
  output logic [AW-1:0] fault_addr,
  output logic          fault_write
);
  logic legal;
  assign legal = (reason == RSN_OK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      resp_accept <= 1'b0;
      resp_reason <= RSN_OK;
      wr_commit   <= 1'b0;
      rd_data     <= '0;
      core_fault  <= 1'b0;
      sys_hwerr   <= 1'b0;
      fault_addr  <= '0;
      fault_write <= 1'b0;
    end else begin
      resp_valid <= valid;
      wr_commit  <= valid && legal && write;
      core_fault <= valid && hit_core;
      sys_hwerr  <= valid && hit_sys;
      rd_data    <= (valid && legal && !write) ? rdata_in : '0;
      if (valid) begin
        resp_accept <= legal;
        resp_reason <= reason;
      end
      if (valid && (hit_core || hit_sys)) begin
        fault_addr  <= addr;
        fault_write <= write;
      end
    end
  end
endmodule

// File: rtl/rwv_access_validator.sv
module rwv_access_validator
  import rwv_pkg::*;
#(
  parameter int            AW        = 32,
  parameter int            DW        = 32,
  parameter int            NBW       = 3,
  parameter logic [AW-1:0] CORE_BASE = 32'hFFE0_0000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic [AW-1:0]  req_addr,
  input  logic [NBW-1:0] req_nbytes,
  input  logic           req_write,
  input  logic           req_from_cpu,
  input  logic           reg_present,
  input  logic           reg_mode,
  input  logic [NBW-1:0] reg_size,
  input  logic [DW-1:0]  reg_rdata,
  output logic           resp_valid,
  output logic           resp_accept,
  output logic [1:0]     resp_reason,
  output logic           wr_commit,
  output logic [DW-1:0]  rd_data,
  output logic           core_fault,
  output logic           sys_hwerr,
  output logic [AW-1:0]  fault_addr,
  output logic           fault_write
);
  // Named internal events, visible to the bound checker.
  logic ev_aligned;
  logic ev_len_ok;
  rsn_e ev_reason;
  logic ev_reject;
  logic ev_in_core;
  logic ev_hit_core;
  logic ev_hit_sys;

  rwv_rule_check #(.AW(AW), .NBW(NBW)) u_rule (
    .addr    (req_addr),
    .nbytes  (req_nbytes),
    .present (reg_present),
    .mode    (reg_mode),
    .size    (reg_size),
    .aligned (ev_aligned),
    .len_ok  (ev_len_ok),
    .reason  (ev_reason)
  );

  assign ev_reject = req_valid && (ev_reason != RSN_OK);

  rwv_route #(.AW(AW), .CORE_BASE(CORE_BASE)) u_route (
    .addr     (req_addr),
    .reject   (ev_reject),
    .from_cpu (req_from_cpu),
    .in_core  (ev_in_core),
    .hit_core (ev_hit_core),
    .hit_sys  (ev_hit_sys)
  );

  rwv_resp_reg #(.AW(AW), .DW(DW)) u_resp (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid       (req_valid),
    .reason      (ev_reason),
    .write       (req_write),
    .addr        (req_addr),
    .rdata_in    (reg_rdata),
    .hit_core    (ev_hit_core),
    .hit_sys     (ev_hit_sys),
    .resp_valid  (resp_valid),
    .resp_accept (resp_accept),
    .resp_reason (resp_reason),
    .wr_commit   (wr_commit),
    .rd_data     (rd_data),
    .core_fault  (core_fault),
    .sys_hwerr   (sys_hwerr),
    .fault_addr  (fault_addr),
    .fault_write (fault_write)
  );
endmodule

// File: rtl/rwv_checker.sv
module rwv_checker #(
  parameter int            AW        = 32,
  parameter int            DW        = 32,
  parameter int            NBW       = 3,
  parameter logic [AW-1:0] CORE_BASE = 32'hFFE0_0000
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic [AW-1:0]  req_addr,
  input logic           req_write,
  input logic           req_from_cpu,
  input logic           reg_present,
  input logic           resp_valid,
  input logic           resp_accept,
  input logic [1:0]     resp_reason,
  input logic           wr_commit,
  input logic [DW-1:0]  rd_data,
  input logic           core_fault,
  input logic           sys_hwerr,
  input logic [AW-1:0]  fault_addr,
  input logic           fault_write
);
  assert_unaligned_refused_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[1:0] != 2'b00) |=> !resp_accept);

  assert_missing_reason_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !reg_present) |=> (resp_reason == 2'd1));

  assert_core_route_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_from_cpu && !reg_present && req_addr >= CORE_BASE)
      |=> (core_fault && fault_addr == $past(req_addr) && fault_write == $past(req_write)));

  assert_sys_route_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_from_cpu && !reg_present && req_addr < CORE_BASE)
      |=> (sys_hwerr && !core_fault));

  assert_silent_initiator_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_from_cpu) |=> (!core_fault && !sys_hwerr && $stable(fault_addr)));

  assert_verdict_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);

  assert_no_spurious_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!core_fault && !sys_hwerr && !resp_valid));

  assert_one_sink_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(core_fault && sys_hwerr));

  assert_commit_needs_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> (resp_valid && resp_accept));

  assert_refused_read_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_accept) |-> (rd_data == '0));
endmodule

bind rwv_access_validator rwv_checker #(
  .AW(AW), .DW(DW), .NBW(NBW), .CORE_BASE(CORE_BASE)
) u_rwv_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_addr     (req_addr),
  .req_write    (req_write),
  .req_from_cpu (req_from_cpu),
  .reg_present  (reg_present),
  .resp_valid   (resp_valid),
  .resp_accept  (resp_accept),
  .resp_reason  (resp_reason),
  .wr_commit    (wr_commit),
  .rd_data      (rd_data),
  .core_fault   (core_fault),
  .sys_hwerr    (sys_hwerr),
  .fault_addr   (fault_addr),
  .fault_write  (fault_write)
);

// File: tb/rwv_access_validator_tb.sv
module rwv_access_validator_tb;
  localparam int          AW   = 32;
  localparam int          DW   = 32;
  localparam int          NBW  = 3;
  localparam logic [31:0] BASE = 32'hFFE0_0000;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           req_valid = 1'b0;
  logic [AW-1:0]  req_addr = '0;
  logic [NBW-1:0] req_nbytes = '0;
  logic           req_write = 1'b0;
  logic           req_from_cpu = 1'b0;
  logic           reg_present = 1'b0;
  logic           reg_mode = 1'b0;
  logic [NBW-1:0] reg_size = '0;
  logic [DW-1:0]  reg_rdata = '0;
  logic           resp_valid, resp_accept, wr_commit, core_fault, sys_hwerr, fault_write;
  logic [1:0]     resp_reason;
  logic [DW-1:0]  rd_data;
  logic [AW-1:0]  fault_addr;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  rwv_access_validator #(.AW(AW), .DW(DW), .NBW(NBW), .CORE_BASE(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_nbytes(req_nbytes), .req_write(req_write), .req_from_cpu(req_from_cpu),
    .reg_present(reg_present), .reg_mode(reg_mode), .reg_size(reg_size),
    .reg_rdata(reg_rdata), .resp_valid(resp_valid), .resp_accept(resp_accept),
    .resp_reason(resp_reason), .wr_commit(wr_commit), .rd_data(rd_data),
    .core_fault(core_fault), .sys_hwerr(sys_hwerr), .fault_addr(fault_addr),
    .fault_write(fault_write)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // Reason as the requirements define it, written without the design's helpers.
  function automatic logic [1:0] model_reason(logic [31:0] a, int nb, logic pres,
                                               logic mode, int sz);
    if (!pres) return 2'd1;
    if (a % 4 != 0) return 2'd2;
    if (mode && !(nb == 2 || nb == 4)) return 2'd3;
    if (!mode && nb != sz) return 2'd3;
    return 2'd0;
  endfunction

  logic [AW-1:0] last_fault_addr = '0;
  logic          last_fault_wr = 1'b0;

  task automatic drive(input logic [31:0] a, input int nb, input logic wr, input logic cpu,
                       input logic pres, input logic mode, input int sz, input logic [31:0] rd);
    req_valid = 1'b1; req_addr = a; req_nbytes = NBW'(nb); req_write = wr;
    req_from_cpu = cpu; reg_present = pres; reg_mode = mode; reg_size = NBW'(sz);
    reg_rdata = rd;
  endtask

  task automatic expect_resp(input string tag, input logic [31:0] a, input int nb,
                             input logic wr, input logic cpu, input logic pres,
                             input logic mode, input int sz, input logic [31:0] rd);
    logic [1:0] r;
    logic ok, core, sys;
    r    = model_reason(a, nb, pres, mode, sz);
    ok   = (r == 2'd0);
    core = !ok && cpu && (a >= BASE);
    sys  = !ok && cpu && (a < BASE);
    if (core || sys) begin last_fault_addr = a; last_fault_wr = wr; end
    chk({tag, " R10 valid"}, resp_valid, 1);
    chk({tag, " R10 accept"}, resp_accept, ok);
    chk({tag, " R5 reason"}, resp_reason, r);
    chk({tag, " R6 core_fault"}, core_fault, core);
    chk({tag, " R7 sys_hwerr"}, sys_hwerr, sys);
    chk({tag, " R11 fault_addr"}, fault_addr, last_fault_addr);
    chk({tag, " R6 fault_write"}, fault_write, last_fault_wr);
    chk({tag, " R12 wr_commit"}, wr_commit, ok && wr);
    chk({tag, " R12 rd_data"}, rd_data, (ok && !wr) ? rd : 32'h0);
  endtask

  // One request, judged one edge later at the following negedge.
  task automatic run_req(input string tag, input logic [31:0] a, input int nb,
                         input logic wr, input logic cpu, input logic pres,
                         input logic mode, input int sz, input logic [31:0] rd);
    @(negedge clk);
    drive(a, nb, wr, cpu, pres, mode, sz, rd);
    @(negedge clk);
    req_valid = 1'b0;
    expect_resp(tag, a, nb, wr, cpu, pres, mode, sz, rd);
  endtask

  task automatic t_reset;
    chk("R10 reset valid", resp_valid, 0);
    chk("R10 reset reason", resp_reason, 0);
    chk("R11 reset faults", {core_fault, sys_hwerr}, 0);
    chk("R11 reset fault_addr", fault_addr, 0);
  endtask

  task automatic t_alignment_R1;
    run_req("R1 aligned", 32'h0000_1000, 4, 0, 1, 1, 0, 4, 32'hA5A5_0001);
    run_req("R1 off1", 32'h0000_1001, 4, 0, 1, 1, 0, 4, 32'h1);
    run_req("R1 off2 half", 32'h0000_1002, 2, 0, 1, 1, 1, 4, 32'h1);
    run_req("R1 off3 byte", 32'h0000_1003, 1, 1, 1, 1, 0, 1, 32'h1);
  endtask

  task automatic t_fixed_R2;
    run_req("R2 match2", 32'h0000_2000, 2, 1, 1, 1, 0, 2, 32'h0);
    run_req("R2 short", 32'h0000_2004, 2, 0, 1, 1, 0, 4, 32'h77);
    run_req("R2 long", 32'h0000_2008, 4, 1, 1, 1, 0, 2, 32'h0);
  endtask

  task automatic t_half_word_R3;
    run_req("R3 two", 32'h0000_3000, 2, 0, 1, 1, 1, 4, 32'h0000_BEEF);
    run_req("R3 four", 32'h0000_3004, 4, 1, 1, 1, 1, 4, 32'h0);
    run_req("R3 one", 32'h0000_3008, 1, 0, 1, 1, 1, 4, 32'h5);
    run_req("R3 three", 32'h0000_300C, 3, 1, 1, 1, 1, 4, 32'h0);
  endtask

  task automatic t_missing_R4_R5;
    run_req("R4 missing", 32'h0000_4000, 4, 0, 1, 0, 0, 4, 32'h9);
    run_req("R5 missing+unaligned", 32'h0000_4002, 3, 0, 1, 0, 0, 4, 32'h9);
    run_req("R5 unaligned+badlen", 32'h0000_4001, 3, 1, 1, 1, 0, 4, 32'h0);
  endtask

  task automatic t_routing_R6_R7_R9;
    run_req("R6 core write", BASE + 32'h100, 4, 1, 1, 0, 0, 4, 32'h0);
    run_req("R7 system read", 32'h0010_0000, 2, 0, 1, 1, 0, 4, 32'h3);
    run_req("R9 at base", BASE, 4, 0, 1, 0, 0, 4, 32'h0);
    run_req("R9 below base", BASE - 32'd4, 4, 1, 1, 0, 0, 4, 32'h0);
    run_req("R9 top", 32'hFFFF_FFFC, 1, 0, 1, 1, 0, 4, 32'h0);
  endtask

  task automatic t_silent_R8;
    run_req("R8 dma core", BASE + 32'h40, 4, 1, 0, 0, 0, 4, 32'h0);
    run_req("R8 debug sys", 32'h0000_0013, 4, 0, 0, 1, 0, 4, 32'h1);
  endtask

  task automatic t_pulse_R11;
    logic [31:0] held;
    run_req("R11 fault", 32'h0000_5001, 4, 1, 1, 1, 0, 4, 32'h0);
    held = fault_addr;
    @(negedge clk);
    chk("R11 pulse gone", {core_fault, sys_hwerr}, 0);
    chk("R11 addr held", fault_addr, held);
    chk("R10 reason held", resp_reason, 2'd2);
  endtask

  task automatic t_gating_R12;
    run_req("R12 ok read", 32'h0000_6000, 4, 0, 1, 1, 0, 4, 32'hCAFE_F00D);
    run_req("R12 bad read", 32'h0000_6004, 2, 0, 1, 1, 0, 4, 32'hCAFE_F00D);
    run_req("R12 ok write", 32'h0000_6008, 4, 1, 1, 1, 1, 4, 32'h0);
    run_req("R12 bad write", 32'h0000_600A, 4, 1, 1, 1, 1, 4, 32'h0);
  endtask

  // Back-to-back refusals routed to opposite sides.
  task automatic t_back_to_back;
    @(negedge clk);
    drive(BASE + 32'h21, 4, 1, 1, 1, 0, 4, 32'h0);
    @(negedge clk);
    expect_resp("B2B first R6", BASE + 32'h21, 4, 1, 1, 1, 0, 4, 32'h0);
    drive(32'h0000_7000, 4, 0, 1, 0, 0, 4, 32'h0);
    @(negedge clk);
    req_valid = 1'b0;
    expect_resp("B2B second R7", 32'h0000_7000, 4, 0, 1, 0, 0, 4, 32'h0);
    @(negedge clk);
    chk("B2B R11 idle", {core_fault, sys_hwerr, resp_valid}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_alignment_R1();
    t_fixed_R2();
    t_half_word_R3();
    t_missing_R4_R5();
    t_routing_R6_R7_R9();
    t_silent_R8();
    t_pulse_R11();
    t_gating_R12();
    t_back_to_back();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #50000;
    total++;
    bad++;
    $display("FAIL watchdog R10 got=hang expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule